// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences a 10-bit successive-approximation conversion against an external comparator. Software-style control inputs load a configuration word: converter enable, a 4-bit input channel code, two reference-source selects (positive and negative rail chosen independently), a result justification bit and an acquisition delay. A start pulse begins a conversion, and the busy output doubles as the start/status bit: it stays high for the whole conversion and falls when the result is ready.

After the programmed number of acquisition cycles, the controller presents one trial code per clock to the external DAC, most significant bit first, and keeps or drops each trial bit according to the comparator answer returned in the same cycle. In the edge that resolves the last bit, the result is written into an 8-bit high/low register pair, busy falls and a sticky completion flag rises. An asynchronous reset returns every register to its reset value and drops any conversion in flight.

Top module: `adc_sar_ctrl`

## Requirements
- R1: Out of reset, busy, flag, both result bytes and the trial code are 0, the channel select output is 0 and both reference selects are 0.
- R2: A start pulse begins a conversion only when the stored enable bit is 1 and no conversion is running; a start pulse in any other case leaves busy and all outputs unchanged.
- R3: Busy rises in the edge that accepts the start and stays high for exactly N + 10 cycles, where N is the stored acquisition count (N = 0 allowed); the trial code is 0 whenever no trial is in progress, including the N acquisition cycles.
- R4: Trial k (k from 9 down to 0) presents the bits already kept OR'ed with 1 << k; bit k is kept exactly when the comparator input is 1 during that trial.
- R5: In the edge that resolves bit 0, the result pair is loaded, busy falls and the flag rises together; the result pair does not change at any other edge except reset.
- R6: With the justify bit 0, the high byte holds result bits 9:8 in its bits 1:0 with bits 7:2 zero, and the low byte holds result bits 7:0.
- R7: With the justify bit 1, the high byte holds result bits 9:2 and the low byte holds result bits 1:0 in its bits 7:6 with bits 5:0 zero.
- R8: The flag stays 1 until a clear pulse; starting a new conversion does not clear it, and a completion in the same edge as a clear leaves it set.
- R9: Channel codes 0 to 12 drive the channel select output with the same code; codes 13 to 15, and codes 5 to 7 when the reduced-pin variant parameter is set, drive the idle value 15, and the conversion still runs with unchanged timing.
- R10: The positive reference select output equals the stored positive select bit (1 = external pin, 0 = supply) and the negative reference select output equals the stored negative select bit likewise.
- R11: A configuration write while busy is high is ignored.
- R12: Asserting reset during a conversion ends it at once: busy, trial code, flag and result bytes return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, one trial per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Load the configuration fields below |
| ctl_en | input | 1 | Converter enable |
| ctl_chan | input | 4 | Input channel code |
| ctl_vpos_ext | input | 1 | Positive reference from external pin when 1 |
| ctl_vneg_ext | input | 1 | Negative reference from external pin when 1 |
| ctl_ljust | input | 1 | Left-justified result when 1 |
| ctl_acq | input | 4 | Acquisition delay in cycles |
| go_set | input | 1 | Start request pulse |
| flag_clr | input | 1 | Clear the completion flag |
| cmp_hi | input | 1 | Comparator: input at or above trial code |
| busy | output | 1 | Start/status bit, high while converting |
| done_flag | output | 1 | Sticky completion flag |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |
| dac_code | output | 10 | Trial code for the external DAC |
| mux_sel | output | 4 | Channel multiplexer select |
| vref_pos_sel | output | 1 | Positive reference select |
| vref_neg_sel | output | 1 | Negative reference select |

## Verification
A wrong sequencer state shows on the trial code output in the very next cycle, because every trial value depends on the kept bits and bit index, and a miscount of acquisition cycles moves the first nonzero code and the busy fall by whole cycles. A corrupted kept-bit register surfaces as a wrong trial code one cycle later and as a wrong result byte at completion. Configuration faults show at once on the channel and reference select outputs, and a flag fault shows in the cycle after completion or clear.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_TRIAL = 2'd2
    } seq_st_e;

endpackage

// File: rtl/adc_sar_cfg.sv
module adc_sar_cfg #(
    parameter int CHAN_W    = 4,
    parameter int NUM_CHAN  = 13,
    parameter int SMALL_PKG = 0,
    parameter int GAP_LO    = 5,
    parameter int GAP_HI    = 7,
    parameter int ACQ_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              busy_i,
    input  logic              en_w,
    input  logic [CHAN_W-1:0] chan_w,
    input  logic              vpos_w,
    input  logic              vneg_w,
    input  logic              ljust_w,
    input  logic [ACQ_W-1:0]  acq_w,
    output logic              en_o,
    output logic [CHAN_W-1:0] mux_sel_o,
    output logic              vpos_o,
    output logic              vneg_o,
    output logic              ljust_o,
    output logic [ACQ_W-1:0]  acq_o
);
    localparam logic [CHAN_W-1:0] IDLE_SEL = {CHAN_W{1'b1}};

    typedef struct packed {
        logic              en;
        logic [CHAN_W-1:0] chan;
        logic              vpos;
        logic              vneg;
        logic              ljust;
        logic [ACQ_W-1:0]  acq;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic in_range, in_gap, chan_ok;

    always_comb begin
        cfg_d = cfg_q;
        if (ctl_we && !busy_i) begin
            cfg_d.en    = en_w;
            cfg_d.chan  = chan_w;
            cfg_d.vpos  = vpos_w;
            cfg_d.vneg  = vneg_w;
            cfg_d.ljust = ljust_w;
            cfg_d.acq   = acq_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign in_range = (cfg_q.chan < CHAN_W'(NUM_CHAN));

    generate
        if (SMALL_PKG != 0) begin : g_gap
            assign in_gap = (cfg_q.chan >= CHAN_W'(GAP_LO)) &&
                            (cfg_q.chan <= CHAN_W'(GAP_HI));
        end else begin : g_nogap
            assign in_gap = 1'b0;
        end
    endgenerate

    assign chan_ok   = in_range && !in_gap;
    assign mux_sel_o = chan_ok ? cfg_q.chan : IDLE_SEL;
    assign en_o      = cfg_q.en;
    assign vpos_o    = cfg_q.vpos;
    assign vneg_o    = cfg_q.vneg;
    assign ljust_o   = cfg_q.ljust;
    assign acq_o     = cfg_q.acq;

    // R11: configuration frozen during a conversion
    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(cfg_q));

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
    import adc_sar_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int ACQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             en_i,
    input  logic [ACQ_W-1:0] acq_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic [RES_W-1:0] dac_o,
    output logic             done_o,
    output logic [RES_W-1:0] res_o
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [ACQ_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] sar;
    } seq_t;

    seq_t s_d, s_q;
    logic [RES_W-1:0] trial;

    assign trial = s_q.sar | (RES_W'(1) << s_q.idx);

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        dac_o  = '0;
        res_o  = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (go_i && en_i) begin
                    s_d.sar = '0;
                    s_d.idx = TOP_IDX;
                    s_d.cnt = acq_i;
                    s_d.st  = (acq_i == '0) ? ST_TRIAL : ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (s_q.cnt == ACQ_W'(1)) s_d.st = ST_TRIAL;
                s_d.cnt = s_q.cnt - ACQ_W'(1);
            end
            ST_TRIAL: begin
                dac_o = trial;
                if (cmp_i) s_d.sar = trial;
                if (s_q.idx == '0) begin
                    done_o = 1'b1;
                    res_o  = s_d.sar;
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.idx = s_q.idx - IDX_W'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0, idx: '0, sar: '0};
        else        s_q <= s_d;
    end

    assign busy_o = (s_q.st != ST_IDLE);

    // R2: busy only rises after an accepted start
    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(go_i && en_i));

    // R4: kept bits never decrease within a conversion
    p_sar_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_TRIAL && s_q.idx != '0) |=> (s_q.sar >= $past(s_q.sar)));

endmodule

// File: rtl/adc_sar_fmt.sv
module adc_sar_fmt #(
    parameter int RES_W = 10,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [RES_W-1:0] res_i,
    input  logic             ljust_i,
    input  logic             clr_i,
    output logic [REG_W-1:0] hi_o,
    output logic [REG_W-1:0] lo_o,
    output logic             flag_o
);
    localparam int PAD_W  = 2 * REG_W - RES_W;
    localparam int PAIR_W = 2 * REG_W;

    typedef struct packed {
        logic [PAIR_W-1:0] pair;
        logic              flag;
    } fmt_t;

    fmt_t f_d, f_q;
    logic [PAIR_W-1:0] packed_res;

    always_comb begin
        if (ljust_i) packed_res = {res_i, {PAD_W{1'b0}}};
        else         packed_res = {{PAD_W{1'b0}}, res_i};
    end

    always_comb begin
        f_d = f_q;
        if (clr_i) f_d.flag = 1'b0;
        if (done_i) begin
            f_d.pair = packed_res;
            f_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign hi_o   = f_q.pair[PAIR_W-1:REG_W];
    assign lo_o   = f_q.pair[REG_W-1:0];
    assign flag_o = f_q.flag;

    // R5: completion raises the flag
    p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> flag_o);

    // R5: result pair changes only on completion
    p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable({hi_o, lo_o}));

    // R8: flag is sticky until cleared
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl #(
    parameter int RES_W     = 10,
    parameter int REG_W     = 8,
    parameter int CHAN_W    = 4,
    parameter int NUM_CHAN  = 13,
    parameter int SMALL_PKG = 0,
    parameter int ACQ_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_en,
    input  logic [CHAN_W-1:0] ctl_chan,
    input  logic              ctl_vpos_ext,
    input  logic              ctl_vneg_ext,
    input  logic              ctl_ljust,
    input  logic [ACQ_W-1:0]  ctl_acq,
    input  logic              go_set,
    input  logic              flag_clr,
    input  logic              cmp_hi,
    output logic              busy,
    output logic              done_flag,
    output logic [REG_W-1:0]  res_hi,
    output logic [REG_W-1:0]  res_lo,
    output logic [RES_W-1:0]  dac_code,
    output logic [CHAN_W-1:0] mux_sel,
    output logic              vref_pos_sel,
    output logic              vref_neg_sel
);
    logic             en_w, ljust_w, done_w;
    logic [ACQ_W-1:0] acq_w;
    logic [RES_W-1:0] res_w;

    adc_sar_cfg #(
        .CHAN_W(CHAN_W), .NUM_CHAN(NUM_CHAN), .SMALL_PKG(SMALL_PKG),
        .GAP_LO(5), .GAP_HI(7), .ACQ_W(ACQ_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .busy_i(busy),
        .en_w(ctl_en), .chan_w(ctl_chan), .vpos_w(ctl_vpos_ext),
        .vneg_w(ctl_vneg_ext), .ljust_w(ctl_ljust), .acq_w(ctl_acq),
        .en_o(en_w), .mux_sel_o(mux_sel), .vpos_o(vref_pos_sel),
        .vneg_o(vref_neg_sel), .ljust_o(ljust_w), .acq_o(acq_w)
    );

    adc_sar_seq #(.RES_W(RES_W), .ACQ_W(ACQ_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .go_i(go_set), .en_i(en_w),
        .acq_i(acq_w), .cmp_i(cmp_hi), .busy_o(busy), .dac_o(dac_code),
        .done_o(done_w), .res_o(res_w)
    );

    adc_sar_fmt #(.RES_W(RES_W), .REG_W(REG_W)) fmt_i (
        .clk(clk), .rst_n(rst_n), .done_i(done_w), .res_i(res_w),
        .ljust_i(ljust_w), .clr_i(flag_clr), .hi_o(res_hi), .lo_o(res_lo),
        .flag_o(done_flag)
    );

endmodule

// File: tb/adc_sar_ctrl_tb.sv
module adc_sar_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 0, ctl_en = 0, ctl_vpos_ext = 0, ctl_vneg_ext = 0, ctl_ljust = 0;
    logic [3:0] ctl_chan = 0, ctl_acq = 0;
    logic       go_set = 0, flag_clr = 0;
    logic       cmp_hi;
    logic       busy, done_flag, vref_pos_sel, vref_neg_sel;
    logic [7:0] res_hi, res_lo;
    logic [9:0] dac_code;
    logic [3:0] mux_sel;
    logic [9:0] vin [16];

    int nchk = 0, nerr = 0, cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign cmp_hi = (vin[mux_sel] >= dac_code);

    adc_sar_ctrl #(.SMALL_PKG(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en),
        .ctl_chan(ctl_chan), .ctl_vpos_ext(ctl_vpos_ext), .ctl_vneg_ext(ctl_vneg_ext),
        .ctl_ljust(ctl_ljust), .ctl_acq(ctl_acq), .go_set(go_set), .flag_clr(flag_clr),
        .cmp_hi(cmp_hi), .busy(busy), .done_flag(done_flag), .res_hi(res_hi),
        .res_lo(res_lo), .dac_code(dac_code), .mux_sel(mux_sel),
        .vref_pos_sel(vref_pos_sel), .vref_neg_sel(vref_neg_sel)
    );

    // behavioural reference model
    int m_busy, m_cnt, m_idx, m_sar, m_hi, m_lo, m_flag;
    int m_en, m_chan, m_vp, m_vn, m_lj, m_acq;

    function automatic int exp_sel(input int ch);
        if (ch > 12 || (ch >= 5 && ch <= 7)) return 15;
        return ch;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_idx = 0; m_sar = 0; m_hi = 0; m_lo = 0; m_flag = 0;
            m_en = 0; m_chan = 0; m_vp = 0; m_vn = 0; m_lj = 0; m_acq = 0;
        end else begin
            int pre_busy, pre_en, pre_acq, trial;
            bit fin;
            pre_busy = m_busy; pre_en = m_en; pre_acq = m_acq; fin = 0;
            if (m_busy != 0) begin
                if (m_cnt > 0) m_cnt = m_cnt - 1;
                else begin
                    trial = m_sar | (1 << m_idx);
                    if (int'(vin[exp_sel(m_chan)]) >= trial) m_sar = trial;
                    if (m_idx == 0) begin
                        fin = 1; m_busy = 0;
                        if (m_lj != 0) begin m_hi = m_sar >> 2; m_lo = (m_sar & 3) << 6; end
                        else begin m_hi = m_sar >> 8; m_lo = m_sar & 255; end
                    end else m_idx = m_idx - 1;
                end
            end else if (go_set && pre_en != 0) begin
                m_busy = 1; m_cnt = pre_acq; m_idx = 9; m_sar = 0;
            end
            if (fin) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (ctl_we && pre_busy == 0) begin
                m_en = ctl_en; m_chan = ctl_chan; m_vp = ctl_vpos_ext;
                m_vn = ctl_vneg_ext; m_lj = ctl_ljust; m_acq = ctl_acq;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 busy", 32'(busy), 32'(m_busy));
            chk("R4 dac_code", 32'(dac_code),
                (m_busy != 0 && m_cnt == 0) ? 32'(m_sar | (1 << m_idx)) : 32'd0);
            chk(m_lj != 0 ? "R7 res_hi" : "R6 res_hi", 32'(res_hi), 32'(m_hi));
            chk(m_lj != 0 ? "R7 res_lo" : "R6 res_lo", 32'(res_lo), 32'(m_lo));
            chk("R8 flag", 32'(done_flag), 32'(m_flag));
            chk("R9 mux_sel", 32'(mux_sel), 32'(exp_sel(m_chan)));
            chk("R10 vref_pos", 32'(vref_pos_sel), 32'(m_vp));
            chk("R10 vref_neg", 32'(vref_neg_sel), 32'(m_vn));
        end
    end

    task automatic report;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            report();
        end
    end

    task automatic step; @(negedge clk); #1; endtask

    task automatic cfg(input int en, input int ch, input int lj, input int acq,
                       input int vp, input int vn);
        step();
        ctl_we = 1; ctl_en = en[0]; ctl_chan = ch[3:0]; ctl_ljust = lj[0];
        ctl_acq = acq[3:0]; ctl_vpos_ext = vp[0]; ctl_vneg_ext = vn[0];
        step();
        ctl_we = 0;
    endtask

    task automatic start; go_set = 1; step(); go_set = 0; endtask

    task automatic wait_idle; while (busy) step(); endtask

    initial begin
        for (int i = 0; i < 16; i++) vin[i] = 10'(i * 61 + 7);
        vin[0] = 10'h200; vin[2] = 10'h2A5; vin[12] = 10'h3FF; vin[3] = 10'h000; vin[15] = 10'h000;
        repeat (3) step();
        // R1: reset values
        chk("R1 busy", 32'(busy), 0);
        chk("R1 flag", 32'(done_flag), 0);
        chk("R1 result", {16'd0, res_hi, res_lo}, 0);
        chk("R1 dac", 32'(dac_code), 0);
        chk("R1 sel", {mux_sel, vref_pos_sel, vref_neg_sel}, 0);
        rst_n = 1;
        step();
        // R2: start while disabled ignored
        start(); step();
        chk("R2 disabled start", 32'(busy), 0);
        // right justified, ch2, acq 3
        cfg(1, 2, 0, 3, 0, 0);
        start();
        chk("R3 busy after start", 32'(busy), 1);
        for (int i = 0; i < 12; i++) begin
            if (i == 5) begin go_set = 1; step(); go_set = 0; end   // R2: start while busy
            else step();
        end
        wait_idle();
        chk("R5 flag at done", 32'(done_flag), 1);
        chk("R6 hi", 32'(res_hi), 32'h02);
        chk("R6 lo", 32'(res_lo), 32'hA5);
        // R7 left justified, acq 0
        cfg(1, 12, 1, 0, 1, 0);
        start(); wait_idle();
        chk("R7 hi", 32'(res_hi), 32'hFF);
        chk("R7 lo", 32'(res_lo), 32'hC0);
        chk("R10 vpos ext", 32'(vref_pos_sel), 1);
        // R8 flag stays across a new start, then clears
        cfg(1, 0, 0, 2, 0, 1);
        start(); step();
        chk("R8 flag kept on start", 32'(done_flag), 1);
        wait_idle();
        chk("R4 boundary 0x200", {16'd0, res_hi, res_lo}, 32'h0200);
        flag_clr = 1; step(); flag_clr = 0; step();
        chk("R8 flag cleared", 32'(done_flag), 0);
        // R9 invalid codes
        cfg(1, 14, 0, 1, 0, 0);
        chk("R9 idle sel 14", 32'(mux_sel), 15);
        start(); wait_idle();
        chk("R9 idle result", {16'd0, res_hi, res_lo}, 0);
        cfg(1, 6, 0, 0, 1, 1);
        chk("R9 gap sel 6", 32'(mux_sel), 15);
        chk("R10 vneg ext", 32'(vref_neg_sel), 1);
        start(); wait_idle();
        cfg(1, 5, 0, 0, 0, 0);
        chk("R9 gap sel 5", 32'(mux_sel), 15);
        cfg(1, 8, 0, 0, 0, 0);
        chk("R9 sel 8", 32'(mux_sel), 8);
        // R11 config write while busy
        cfg(1, 4, 0, 4, 0, 0);
        start();
        ctl_we = 1; ctl_chan = 4'd9; ctl_ljust = 1; step(); ctl_we = 0;
        chk("R11 sel unchanged", 32'(mux_sel), 4);
        wait_idle();
        chk("R11 justify unchanged", 32'(res_hi), 32'(vin[4] >> 8));
        // R12 reset during conversion
        cfg(1, 2, 0, 1, 0, 0);
        start(); repeat (4) step();
        rst_n = 0; #2;
        chk("R12 busy", 32'(busy), 0);
        chk("R12 dac", 32'(dac_code), 0);
        chk("R12 flag", 32'(done_flag), 0);
        chk("R12 result", {16'd0, res_hi, res_lo}, 0);
        step(); rst_n = 1; step();
        cfg(1, 3, 0, 0, 0, 0);
        start(); wait_idle();
        chk("R4 zero input", {16'd0, res_hi, res_lo}, 0);
        repeat (3) step();
        report();
    end

endmodule